// File: doc/BRIEF.md
# Debug Command Word Sequencer

This block sits behind a host debug port and turns a stream of 16-bit words into single register or memory accesses. The first word of each command is split into its fields. The block then counts and gathers the extension words that this command needs: an absolute memory address, immediate write data, or both. After that it raises one access request with a size-aligned address and sized write data, and it returns the result to the host as 16-bit response words.

The opcode bits are not interpreted here. They are sent out on `opc`, and an external table answers on `opc_class` in the same cycle to say whether the command targets a register or memory, or is unknown. Responses overlap with requests. The response word the host reads during any transfer belongs to the word or command that came before it. While an access is outstanding, the host reads a not-ready code and any words it sends are dropped. A write answers with a fixed completion code. A malformed command answers with an illegal code and starts no access. Each response word carries a status flag that separates these codes from read data.

Top module: `dbg_cmd_seq`

## Requirements
- R1: Command word fields: `opc` is word[15:10]. Bit 7 set means a read (`acc_write`=0) and bit 7 clear means a write. Word[5:4] gives the size (00 byte, 01 word, 10 long), word[3] gives the register kind (`acc_ad`, 1 selects an address register), and word[2:0] gives the register number. All of these are shown on the request.
- R2: A command is illegal if word[9], word[8] or word[6] is set, if the size is 11, or if `opc_class` is 2 or 3. An illegal command issues no request and makes the response {status 1, `RSP_ILLEGAL`}.
- R3: A memory command (`opc_class`=1) takes two address words. A write takes one data word for byte or word size and two for long. A register command (`opc_class`=0) takes no address words. The request rises right after the last required word is received, or right after the command word when no extension words are needed.
- R4: The address and long write data are assembled from their words with the most-significant word first.
- R5: A word-sized memory address has bit 0 forced to 0. A long-sized memory address has bits 1:0 forced to 0. Register requests drive an address of 0.
- R6: Byte write data is bits 7:0 of its extension word, zero-extended to 32 bits. Word write data is the whole extension word, zero-extended.
- R7: Read results have status 0. A byte read returns {8'h00, rdata[7:0]}. A word read returns rdata[15:0]. A long read returns rdata[31:16] and then rdata[15:0], one per host transfer. The transfer that collects the high half is not decoded as a command.
- R8: The response word visible during a host transfer is the result of the previous command or word.
- R9: From the moment a legal command is accepted until its access is acknowledged, the response is {status 1, `RSP_NOT_READY`}. Words received while the request is pending are ignored.
- R10: A write that is acknowledged returns {status 1, `RSP_DONE`}.
- R11: After reset the response is {status 1, `RSP_NOT_READY`} and no request is raised.
- R12: While the request is not acknowledged, it stays high with stable address, data and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | A host word is transferred this cycle |
| host_word | input | 16 | Word sent by the host |
| host_rsp_stat | output | 1 | 1 = response is a status code, 0 = read data |
| host_rsp | output | 16 | Response word read by the host during a transfer |
| opc | output | 6 | Opcode field of the word on `host_word` |
| opc_class | input | 2 | Class of `opc`: 0 register, 1 memory, 2/3 unknown |
| acc_req | output | 1 | Access request pending |
| acc_mem | output | 1 | 1 = memory access, 0 = register access |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_size | output | 2 | Operand size code |
| acc_ad | output | 1 | Register kind: 1 address, 0 data |
| acc_reg | output | 3 | Register number |
| acc_addr | output | 32 | Aligned memory address |
| acc_wdata | output | 32 | Sized write data |
| acc_ack | input | 1 | Access done; `acc_rdata` valid for reads |
| acc_rdata | input | 32 | Read data |

## Verification
The bench builds the block with the three response codes overridden to 16'h5A5A (not ready), 16'hBAD1 (illegal) and 16'hD0DE (done), so each code differs from the reset-default values and from zero. This shows that every status word comes from its own parameter and not from a hard-wired constant. The access responder acknowledges after a random delay of zero to three cycles. This covers both an acknowledge in the cycle right after the request and host words arriving while the request is pending.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
  localparam int WORD_W     = 16;
  localparam int DATA_W     = 2 * WORD_W;
  localparam int OPC_W      = 6;
  localparam int REGN_W     = 3;
  localparam int CNT_W      = 3;
  localparam int ADDR_WORDS = DATA_W / WORD_W;
  localparam int BYTE_W     = 8;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  localparam logic [1:0] CLS_REG = 2'd0;
  localparam logic [1:0] CLS_MEM = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_WAIT, ST_OUT} st_e;

  function automatic logic [CNT_W-1:0] data_words(input logic [1:0] sz);
    return (sz == SZ_LONG) ? CNT_W'(2) : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] ext_words(input logic mem, input logic wr,
                                                 input logic [1:0] sz);
    logic [CNT_W-1:0] n;
    n = mem ? CNT_W'(ADDR_WORDS) : '0;
    if (wr) n = n + data_words(sz);
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] force_align(input logic [DATA_W-1:0] a,
                                                    input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = a;
    if (sz == SZ_WORD) r[0] = 1'b0;
    if (sz == SZ_LONG) r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] size_data(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(DATA_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
      SZ_WORD: r = {{(DATA_W-WORD_W){1'b0}}, d[WORD_W-1:0]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbgseq_decode.sv
module dbgseq_decode
  import dbgseq_pkg::*;
(
  input  logic [9:0]        cmd_lo,
  input  logic [1:0]        cls,
  output logic              legal,
  output logic              is_mem,
  output logic              is_write,
  output logic [1:0]        size,
  output logic              ad,
  output logic [REGN_W-1:0] regn,
  output logic [CNT_W-1:0]  n_ext
);
  logic rsv_ok, cls_ok;

  assign rsv_ok   = (cmd_lo[9:8] == 2'b00) && !cmd_lo[6];
  assign cls_ok   = (cls == CLS_REG) || (cls == CLS_MEM);
  assign size     = cmd_lo[5:4];
  assign is_write = !cmd_lo[7];
  assign ad       = cmd_lo[3];
  assign regn     = cmd_lo[REGN_W-1:0];
  assign is_mem   = (cls == CLS_MEM);
  assign legal    = rsv_ok && cls_ok && (size != SZ_RSVD);
  assign n_ext    = ext_words(is_mem, is_write, size);
endmodule

// File: rtl/dbgseq_collect.sv
module dbgseq_collect
  import dbgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  input  logic              mem,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] addr_raw, data_raw;
  logic              to_addr;

  assign to_addr = mem && (idx < CNT_W'(ADDR_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      addr_raw <= '0;
      data_raw <= '0;
    end else if (start) begin
      idx      <= '0;
      addr_raw <= '0;
      data_raw <= '0;
    end else if (push) begin
      idx <= idx + CNT_W'(1);
      if (to_addr) addr_raw <= {addr_raw[DATA_W-WORD_W-1:0], word};
      else         data_raw <= {data_raw[DATA_W-WORD_W-1:0], word};
    end
  end

  assign addr  = mem ? force_align(addr_raw, size) : '0;
  assign wdata = size_data(data_raw, size);
endmodule

// File: rtl/dbgseq_format.sv
module dbgseq_format
  import dbgseq_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] first,
  output logic [WORD_W-1:0] second,
  output logic              two
);
  logic [DATA_W-1:0] sized;

  assign sized  = size_data(rdata, size);
  assign two    = (size == SZ_LONG);
  assign first  = two ? rdata[DATA_W-1:WORD_W] : sized[WORD_W-1:0];
  assign second = rdata[WORD_W-1:0];
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbgseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RSP_NOT_READY = 16'h0000,
  parameter logic [WORD_W-1:0] RSP_ILLEGAL   = 16'h0001,
  parameter logic [WORD_W-1:0] RSP_DONE      = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic [WORD_W-1:0] host_word,
  output logic              host_rsp_stat,
  output logic [WORD_W-1:0] host_rsp,
  output logic [OPC_W-1:0]  opc,
  input  logic [1:0]        opc_class,
  output logic              acc_req,
  output logic              acc_mem,
  output logic              acc_write,
  output logic [1:0]        acc_size,
  output logic              acc_ad,
  output logic [REGN_W-1:0] acc_reg,
  output logic [DATA_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_ack,
  input  logic [DATA_W-1:0] acc_rdata
);
  st_e               state;
  logic [CNT_W-1:0]  rem;
  logic              c_mem, c_wr, c_ad;
  logic [1:0]        c_size;
  logic [REGN_W-1:0] c_reg;
  logic              rsp_stat_q;
  logic [WORD_W-1:0] rsp_q, tail_q;

  logic              d_legal, d_mem, d_wr, d_ad;
  logic [1:0]        d_size;
  logic [REGN_W-1:0] d_reg;
  logic [CNT_W-1:0]  d_next;
  logic [WORD_W-1:0] f_first, f_second;
  logic              f_two;

  // Named internal events
  logic ev_cmd_take, ev_cmd_bad, ev_cmd_good, ev_ext_take, ev_acc_done;

  assign opc = host_word[WORD_W-1:WORD_W-OPC_W];

  dbgseq_decode u_dec (
    .cmd_lo  (host_word[9:0]),
    .cls     (opc_class),
    .legal   (d_legal),
    .is_mem  (d_mem),
    .is_write(d_wr),
    .size    (d_size),
    .ad      (d_ad),
    .regn    (d_reg),
    .n_ext   (d_next)
  );

  assign ev_cmd_take = (state == ST_IDLE) && host_valid;
  assign ev_cmd_bad  = ev_cmd_take && !d_legal;
  assign ev_cmd_good = ev_cmd_take && d_legal;
  assign ev_ext_take = (state == ST_EXT) && host_valid;
  assign ev_acc_done = (state == ST_WAIT) && acc_ack;

  dbgseq_collect u_col (
    .clk  (clk),
    .rst_n(rst_n),
    .start(ev_cmd_good),
    .push (ev_ext_take),
    .word (host_word),
    .mem  (c_mem),
    .size (c_size),
    .addr (acc_addr),
    .wdata(acc_wdata)
  );

  dbgseq_format u_fmt (
    .rdata (acc_rdata),
    .size  (c_size),
    .first (f_first),
    .second(f_second),
    .two   (f_two)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rem        <= '0;
      c_mem      <= 1'b0;
      c_wr       <= 1'b0;
      c_ad       <= 1'b0;
      c_size     <= SZ_BYTE;
      c_reg      <= '0;
      rsp_stat_q <= 1'b1;
      rsp_q      <= RSP_NOT_READY;
      tail_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ev_cmd_bad) begin
            rsp_stat_q <= 1'b1;
            rsp_q      <= RSP_ILLEGAL;
          end else if (ev_cmd_good) begin
            c_mem      <= d_mem;
            c_wr       <= d_wr;
            c_ad       <= d_ad;
            c_size     <= d_size;
            c_reg      <= d_reg;
            rem        <= d_next;
            rsp_stat_q <= 1'b1;
            rsp_q      <= RSP_NOT_READY;
            state      <= (d_next == '0) ? ST_WAIT : ST_EXT;
          end
        end
        ST_EXT: begin
          if (ev_ext_take) begin
            rem <= rem - CNT_W'(1);
            if (rem == CNT_W'(1)) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ev_acc_done) begin
            if (c_wr) begin
              rsp_stat_q <= 1'b1;
              rsp_q      <= RSP_DONE;
              state      <= ST_IDLE;
            end else begin
              rsp_stat_q <= 1'b0;
              rsp_q      <= f_first;
              tail_q     <= f_second;
              state      <= f_two ? ST_OUT : ST_IDLE;
            end
          end
        end
        ST_OUT: begin
          if (host_valid) begin
            rsp_stat_q <= 1'b0;
            rsp_q      <= tail_q;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_rsp_stat = rsp_stat_q;
  assign host_rsp      = rsp_q;
  assign acc_req       = (state == ST_WAIT);
  assign acc_mem       = c_mem;
  assign acc_write     = c_wr;
  assign acc_size      = c_size;
  assign acc_ad        = c_ad;
  assign acc_reg       = c_reg;
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk
  import dbgseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] NR   = 16'h0000,
  parameter logic [WORD_W-1:0] ILL  = 16'h0001,
  parameter logic [WORD_W-1:0] DONE = 16'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rsp_stat,
  input logic [WORD_W-1:0] host_rsp,
  input logic              acc_req,
  input logic              acc_ack,
  input logic              acc_mem,
  input logic              acc_write,
  input logic [1:0]        acc_size,
  input logic [DATA_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              ev_cmd_bad,
  input logic              ev_acc_done
);
  a_r2_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_bad |=> !acc_req && host_rsp_stat && host_rsp == ILL);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_wdata)
                            && $stable(acc_size) && $stable(acc_write));

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_mem && acc_size == SZ_WORD |-> !acc_addr[0]);

  a_r5_long_align: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_mem && acc_size == SZ_LONG |-> acc_addr[1:0] == 2'b00);

  a_r9_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> host_rsp_stat && host_rsp == NR);

  a_r10_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_acc_done && acc_write |=> !acc_req && host_rsp_stat && host_rsp == DONE);

  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_acc_done && !acc_write && acc_size == SZ_BYTE
      |=> !host_rsp_stat && host_rsp[WORD_W-1:BYTE_W] == '0);
endmodule

bind dbg_cmd_seq dbgseq_chk #(
  .NR  (RSP_NOT_READY),
  .ILL (RSP_ILLEGAL),
  .DONE(RSP_DONE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rsp_stat(host_rsp_stat),
  .host_rsp     (host_rsp),
  .acc_req      (acc_req),
  .acc_ack      (acc_ack),
  .acc_mem      (acc_mem),
  .acc_write    (acc_write),
  .acc_size     (acc_size),
  .acc_addr     (acc_addr),
  .acc_wdata    (acc_wdata),
  .ev_cmd_bad   (ev_cmd_bad),
  .ev_acc_done  (ev_acc_done)
);

// File: tb/dbg_cmd_seq_tb.sv
`timescale 1ns/1ps
module dbg_cmd_seq_tb;
  localparam logic [15:0] NR  = 16'h5A5A;
  localparam logic [15:0] ILL = 16'hBAD1;
  localparam logic [15:0] DN  = 16'hD0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic [15:0] host_word = '0;
  logic        host_rsp_stat;
  logic [15:0] host_rsp;
  logic [5:0]  opc;
  logic [1:0]  opc_class = '0;
  logic        acc_req, acc_mem, acc_write, acc_ad;
  logic [1:0]  acc_size;
  logic [2:0]  acc_reg;
  logic [31:0] acc_addr, acc_wdata;
  logic        acc_ack = 1'b0;
  logic [31:0] acc_rdata = '0;

  dbg_cmd_seq #(.RSP_NOT_READY(NR), .RSP_ILLEGAL(ILL), .RSP_DONE(DN)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_word(host_word),
    .host_rsp_stat(host_rsp_stat), .host_rsp(host_rsp), .opc(opc),
    .opc_class(opc_class), .acc_req(acc_req), .acc_mem(acc_mem),
    .acc_write(acc_write), .acc_size(acc_size), .acc_ad(acc_ad),
    .acc_reg(acc_reg), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, acks = 0;
  bit ack_seen = 0, done = 0;
  int lat = 0;
  logic        cap_mem, cap_wr, cap_ad;
  logic [1:0]  cap_size;
  logic [2:0]  cap_reg;
  logic [31:0] cap_addr, cap_wdata, cap_rdata;
  bit          p_s = 1;
  logic [15:0] p_d = NR;
  string       p_tag = "R11";

  // Access responder: acknowledges after 0..3 cycles with random data
  always begin
    @(negedge clk); #2;
    if (acc_ack) acc_ack = 1'b0;
    else if (acc_req) begin
      if (lat == 0) begin
        acc_ack = 1'b1; acc_rdata = $urandom;
        cap_mem = acc_mem; cap_wr = acc_write; cap_ad = acc_ad;
        cap_size = acc_size; cap_reg = acc_reg; cap_addr = acc_addr;
        cap_wdata = acc_wdata; cap_rdata = acc_rdata;
        acks++; ack_seen = 1; lat = $urandom % 4;
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [32:0] act,
                     input logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [5:0] op, input bit rd,
                                     input logic [1:0] sz, input bit ad,
                                     input logic [2:0] rg);
    return {op, 2'b00, rd, 1'b0, sz, ad, rg};
  endfunction

  function automatic logic [31:0] exp_align(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'b01) return {a[31:1], 1'b0};
    if (sz == 2'b10) return {a[31:2], 2'b00};
    return a;
  endfunction

  task automatic xfer(input logic [15:0] w, input logic [1:0] cls, input bit es,
                      input logic [15:0] ed, input string req);
    @(negedge clk);
    host_valid = 1'b1; host_word = w; opc_class = cls;
    #1;
    chk(host_rsp_stat == es && host_rsp == ed, req, {host_rsp_stat, host_rsp}, {es, ed});
    chk(opc == w[15:10], "R1 opc", {27'd0, opc}, {27'd0, w[15:10]});
    @(posedge clk); #1;
    host_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] w, input logic [1:0] cls,
                         input logic [15:0] e0, input logic [15:0] e1,
                         input logic [15:0] e2, input logic [15:0] e3);
    logic [15:0] ex [4];
    bit mem, wr, legal;
    logic [1:0] sz;
    int n, k, a0;
    logic [31:0] wexp, aexp;
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    mem = (cls == 2'd1); wr = !w[7]; sz = w[5:4];
    legal = (w[9:8] == 2'b00) && !w[6] && sz != 2'b11 && cls < 2'd2;
    n = (mem ? 2 : 0) + (wr ? ((sz == 2'b10) ? 2 : 1) : 0);
    a0 = acks;
    xfer(w, cls, p_s, p_d, $sformatf("R8 %s", p_tag));
    if (!legal) begin
      repeat (3) @(negedge clk);
      chk(acks == a0 && !acc_req, "R2 no access", {32'd0, acc_req}, 33'd0);
      p_s = 1; p_d = ILL; p_tag = "R2";
      return;
    end
    for (int i = 0; i < n; i++) begin
      chk(!acc_req, "R3 early request", {32'd0, acc_req}, 33'd0);
      xfer(ex[i], 2'($urandom), 1'b1, NR, "R9 during ext");
    end
    chk(acc_req || acks != a0, "R3 request after last word", {32'd0, acc_req}, 33'd1);
    while (!ack_seen) xfer(16'($urandom), 2'($urandom), 1'b1, NR, "R9 pending");
    ack_seen = 0;
    chk(cap_wr == wr && cap_size == sz && cap_ad == w[3] && cap_reg == w[2:0]
        && cap_mem == mem, "R1 fields",
        {26'd0, cap_mem, cap_wr, cap_size, cap_ad, cap_reg},
        {26'd0, mem, wr, sz, w[3], w[2:0]});
    aexp = mem ? exp_align({ex[0], ex[1]}, sz) : 32'd0;
    chk(cap_addr == aexp, "R4 R5 address", {1'b0, cap_addr}, {1'b0, aexp});
    if (wr) begin
      k = mem ? 2 : 0;
      if (sz == 2'b10) wexp = {ex[k], ex[k+1]};
      else if (sz == 2'b01) wexp = {16'd0, ex[k]};
      else wexp = {24'd0, ex[k][7:0]};
      chk(cap_wdata == wexp, "R6 R4 write data", {1'b0, cap_wdata}, {1'b0, wexp});
      p_s = 1; p_d = DN; p_tag = "R10";
    end else if (sz == 2'b10) begin
      xfer(16'($urandom), 2'($urandom), 1'b0, cap_rdata[31:16], "R7 long high");
      p_s = 0; p_d = cap_rdata[15:0]; p_tag = "R7 long low";
    end else begin
      p_s = 0; p_tag = "R7 short";
      p_d = (sz == 2'b01) ? cap_rdata[15:0] : {8'h00, cap_rdata[7:0]};
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(host_rsp_stat && host_rsp == NR && !acc_req, "R11 reset",
        {host_rsp_stat, host_rsp}, {1'b1, NR});
    // Directed corner cases
    run_cmd(mk(6'h05, 1, 2'b00, 0, 3'd0), 2'd1, 16'h1234, 16'h5677, 0, 0);
    run_cmd(mk(6'h06, 0, 2'b01, 0, 3'd0), 2'd1, 16'hABCD, 16'h0003, 16'hBEEF, 0);
    run_cmd(mk(6'h05, 1, 2'b10, 0, 3'd0), 2'd1, 16'h0000, 16'hFFFF, 0, 0);
    run_cmd(mk(6'h06, 0, 2'b10, 0, 3'd0), 2'd1, 16'h8000, 16'h0006, 16'hCAFE, 16'hF00D);
    run_cmd(mk(6'h02, 0, 2'b10, 1, 3'd7), 2'd0, 16'h1357, 16'h9BDF, 0, 0);
    run_cmd(mk(6'h01, 1, 2'b00, 0, 3'd2), 2'd0, 0, 0, 0, 0);
    run_cmd(mk(6'h02, 0, 2'b00, 0, 3'd4), 2'd0, 16'h12FF, 0, 0, 0);
    run_cmd(mk(6'h05, 1, 2'b11, 0, 3'd0), 2'd1, 0, 0, 0, 0);
    run_cmd(mk(6'h05, 1, 2'b01, 0, 3'd0) | 16'h0200, 2'd1, 0, 0, 0, 0);
    run_cmd(mk(6'h05, 1, 2'b01, 0, 3'd0) | 16'h0100, 2'd1, 0, 0, 0, 0);
    run_cmd(mk(6'h05, 1, 2'b01, 0, 3'd0) | 16'h0040, 2'd0, 0, 0, 0, 0);
    run_cmd(mk(6'h3F, 1, 2'b01, 0, 3'd0), 2'd2, 0, 0, 0, 0);
    run_cmd(mk(6'h3E, 0, 2'b01, 0, 3'd0), 2'd3, 0, 0, 0, 0);
    run_cmd(mk(6'h01, 1, 2'b01, 1, 3'd5), 2'd0, 0, 0, 0, 0);
    // Constrained random commands
    for (int i = 0; i < 300; i++) begin
      logic [15:0] w;
      logic [1:0] cls;
      w = mk(6'($urandom), 1'($urandom), 2'($urandom % 3), 1'($urandom), 3'($urandom));
      if ($urandom % 10 == 0) w = w | ({$urandom} & 16'h0370);
      cls = ($urandom % 10 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
      run_cmd(w, cls, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end
    run_cmd(mk(6'h01, 1, 2'b01, 0, 3'd1), 2'd0, 0, 0, 0, 0);
    finish_run();
  end
endmodule